// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads an attached FPGA that takes its bitstream over a slave-serial link. A start pulse begins the handshake. The block pulls the active-low program line low and waits for the FPGA's init line to fall. It then releases the program line and waits for init to rise again. After that it clocks the bitstream out one bit at a time on a data line, using a configuration clock that it generates itself. The last step is to wait for the FPGA's done line to go high.

Bitstream bytes arrive on a valid/ready port, and a last flag marks the final byte. Each of the three waits has its own timeout, counted in system clock cycles, and its own error code. The result stays visible until the next start: either a success flag or a two-bit error code. The init and done inputs must already be synchronous to `clk_i`.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset the outputs are `prog_no`=1, `busy_o`=0, `ok_o`=0, `err_o`=0, `cclk_o`=0 and `byte_ready_o`=0.
- R2: A `start_i` that is sampled while the block is not busy drives `prog_no` low and `busy_o` high from the next cycle on. `prog_no` is low only while busy.
- R3: While `prog_no` is low, `init_i` low moves the block on and releases `prog_no`. If `init_i` stays high for `T_INIT_LOW` cycles, the block stops with `err_o`=2'b01 and `prog_no` high. In that case the phase lasts exactly `T_INIT_LOW` cycles.
- R4: After release, `init_i` high starts the data phase. If `init_i` stays low for `T_INIT_HIGH` cycles, the block stops with `err_o`=2'b10 after exactly `T_INIT_HIGH` busy cycles.
- R5: Each byte is sent most significant bit first. `din_o` only changes while `cclk_o` is low, and the FPGA samples `din_o` on the rising edge of `cclk_o`. Each half-period of `cclk_o` lasts `CCLK_HALF` cycles, so one byte keeps `cclk_o` high for 8*`CCLK_HALF` cycles.
- R6: `byte_ready_o` is high only during the data phase while no byte is being shifted. A byte is taken when `byte_valid_i` and `byte_ready_o` are both high at a clock edge.
- R7: After the byte flagged by `byte_last_i` has been shifted out, `done_i` high sets `ok_o`=1 and clears busy. If `done_i` stays low for `T_DONE` cycles, the block stops with `err_o`=2'b11.
- R8: An error code or the success flag is held, whatever `init_i`, `done_i` and the byte port do, until the next start. That start clears both.
- R9: `start_i` has no effect while busy.
- R10: `cclk_o` stays low whenever the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a configuration run |
| byte_i | input | 8 | Bitstream byte |
| byte_valid_i | input | 1 | Byte is valid |
| byte_last_i | input | 1 | Byte is the final one of the stream |
| byte_ready_o | output | 1 | Block accepts a byte this cycle |
| init_i | input | 1 | FPGA init line (synchronous) |
| done_i | input | 1 | FPGA done line (synchronous) |
| prog_no | output | 1 | FPGA program line, active low |
| cclk_o | output | 1 | Configuration clock |
| din_o | output | 1 | Configuration serial data |
| busy_o | output | 1 | Run in progress |
| ok_o | output | 1 | Last run succeeded |
| err_o | output | 2 | Last run's error code, 0 when none |

## Verification
The hardest cases to reach are the two init timeouts, because they need the FPGA model to withhold one specific edge of the init line. Only that edge is withheld; the rest of the handshake behaves normally. The bench plays the FPGA itself and holds init at one level for each case. For the first timeout it never pulls init low; for the second it pulls init low but never releases it. It counts busy cycles, which exposes off-by-one errors in the timeout. The data path is checked by an independent model that shifts in `din_o` on each rising edge of `cclk_o` and compares the rebuilt bytes. A start pulse injected in the middle of a stream shows that the stream still arrives intact.

// File: rtl/cfg_serial_loader_pkg.sv
package cfg_serial_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_REL, ST_SHIFT, ST_DONEW, ST_FAIL, ST_PASS
  } cfg_state_e;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'b00,
    ERR_INIT_LOW  = 2'b01,
    ERR_INIT_HIGH = 2'b10,
    ERR_DONE      = 2'b11
  } cfg_err_e;
endpackage

// File: rtl/cfg_serial_timer.sv
module cfg_serial_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (cnt_q != {W{1'b1}}) cnt_q <= cnt_q + 1'b1;
  end

  // phase has lasted limit_i cycles at the coming edge
  assign hit_o = (cnt_q >= limit_i - 1'b1);
endmodule

// File: rtl/cfg_serial_shifter.sv
module cfg_serial_shifter #(
  parameter int HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  input  logic       last_i,
  output logic       ready_o,
  output logic       cclk_o,
  output logic       din_o,
  output logic       end_o
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PW-1:0] PH_TOP = PW'(HALF - 1);

  logic [7:0]    sh_q;
  logic [3:0]    bits_q;
  logic          last_q;
  logic          cclk_q;
  logic [PW-1:0] ph_q;
  logic          active;

  assign active  = (bits_q != 4'd0);
  assign ready_o = en_i && !active && !last_q;
  assign end_o   = en_i && last_q && !active;
  assign cclk_o  = cclk_q;
  assign din_o   = sh_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; bits_q <= '0; last_q <= 1'b0; cclk_q <= 1'b0; ph_q <= '0;
    end else if (!en_i) begin
      sh_q <= '0; bits_q <= '0; last_q <= 1'b0; cclk_q <= 1'b0; ph_q <= '0;
    end else if (!active) begin
      if (valid_i && ready_o) begin
        sh_q   <= data_i;
        bits_q <= 4'd8;
        last_q <= last_i;
        ph_q   <= '0;
        cclk_q <= 1'b0;
      end
    end else if (ph_q == PH_TOP) begin
      ph_q <= '0;
      if (!cclk_q) begin
        cclk_q <= 1'b1;
      end else begin
        // data moves only on the falling edge
        cclk_q <= 1'b0;
        sh_q   <= {sh_q[6:0], 1'b0};
        bits_q <= bits_q - 4'd1;
      end
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_serial_loader_pkg::*;
#(
  parameter int T_INIT_LOW  = 1000,
  parameter int T_INIT_HIGH = 1000,
  parameter int T_DONE      = 10000,
  parameter int CCLK_HALF   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       byte_valid_i,
  input  logic       byte_last_i,
  output logic       byte_ready_o,
  input  logic       init_i,
  input  logic       done_i,
  output logic       prog_no,
  output logic       cclk_o,
  output logic       din_o,
  output logic       busy_o,
  output logic       ok_o,
  output logic [1:0] err_o
);
  localparam int TMAX12 = (T_INIT_LOW > T_INIT_HIGH) ? T_INIT_LOW : T_INIT_HIGH;
  localparam int TMAX   = (TMAX12 > T_DONE) ? TMAX12 : T_DONE;
  localparam int TW     = $clog2(TMAX + 1);

  cfg_state_e st_q, st_d;
  cfg_err_e   err_q, err_d;
  logic       tmo_hit, sh_end;
  logic [TW-1:0] limit;

  always_comb begin
    unique case (st_q)
      ST_PROG: limit = TW'(T_INIT_LOW);
      ST_REL:  limit = TW'(T_INIT_HIGH);
      default: limit = TW'(T_DONE);
    endcase
  end

  cfg_serial_timer #(.W(TW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_d != st_q),
    .limit_i (limit),
    .hit_o   (tmo_hit)
  );

  cfg_serial_shifter #(.HALF(CCLK_HALF)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (st_q == ST_SHIFT),
    .data_i  (byte_i),
    .valid_i (byte_valid_i),
    .last_i  (byte_last_i),
    .ready_o (byte_ready_o),
    .cclk_o  (cclk_o),
    .din_o   (din_o),
    .end_o   (sh_end)
  );

  always_comb begin
    st_d  = st_q;
    err_d = err_q;
    unique case (st_q)
      ST_IDLE, ST_FAIL, ST_PASS: if (start_i) begin
        st_d  = ST_PROG;
        err_d = ERR_NONE;
      end
      ST_PROG: if (!init_i) st_d = ST_REL;
        else if (tmo_hit) begin st_d = ST_FAIL; err_d = ERR_INIT_LOW; end
      ST_REL: if (init_i) st_d = ST_SHIFT;
        else if (tmo_hit) begin st_d = ST_FAIL; err_d = ERR_INIT_HIGH; end
      ST_SHIFT: if (sh_end) st_d = ST_DONEW;
      ST_DONEW: if (done_i) st_d = ST_PASS;
        else if (tmo_hit) begin st_d = ST_FAIL; err_d = ERR_DONE; end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      err_q <= ERR_NONE;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign prog_no = (st_q != ST_PROG);
  assign busy_o  = (st_q == ST_PROG) || (st_q == ST_REL) ||
                   (st_q == ST_SHIFT) || (st_q == ST_DONEW);
  assign ok_o    = (st_q == ST_PASS);
  assign err_o   = err_q;
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       byte_ready_o,
  input logic       prog_no,
  input logic       cclk_o,
  input logic       din_o,
  input logic       busy_o,
  input logic       ok_o,
  input logic [1:0] err_o
);
  assert_prog_in_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> busy_o);
  assert_err_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != 2'b00) |-> (!busy_o && !ok_o));
  assert_err_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != 2'b00 && !start_i) |=> $stable(err_o));
  assert_ready_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> (busy_o && prog_no && !cclk_o));
  assert_din_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cclk_o && $past(cclk_o)) |-> $stable(din_o));
  assert_idle_clk_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cclk_o);
  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && prog_no && start_i) |=> prog_no);
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .byte_ready_o (byte_ready_o),
  .prog_no      (prog_no),
  .cclk_o       (cclk_o),
  .din_o        (din_o),
  .busy_o       (busy_o),
  .ok_o         (ok_o),
  .err_o        (err_o)
);

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;
  localparam int T_IL = 20;
  localparam int T_IH = 24;
  localparam int T_DN = 40;
  localparam int HALF = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic byte_valid_i = 1'b0, byte_last_i = 1'b0, init_i = 1'b1, done_i = 1'b0;
  logic byte_ready_o, prog_no, cclk_o, din_o, busy_o, ok_o;
  logic [1:0] err_o;

  cfg_serial_loader #(.T_INIT_LOW(T_IL), .T_INIT_HIGH(T_IH), .T_DONE(T_DN),
                      .CCLK_HALF(HALF)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .byte_i(byte_i),
    .byte_valid_i(byte_valid_i), .byte_last_i(byte_last_i),
    .byte_ready_o(byte_ready_o), .init_i(init_i), .done_i(done_i),
    .prog_no(prog_no), .cclk_o(cclk_o), .din_o(din_o), .busy_o(busy_o),
    .ok_o(ok_o), .err_o(err_o));

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  logic [7:0] rx_sh = '0;
  logic [7:0] rx_mem [32];
  int rx_bits = 0, rx_n = 0, hi_cyc = 0;

  // FPGA model: sample data on rising configuration clock
  always @(posedge cclk_o) begin
    rx_sh = {rx_sh[6:0], din_o};
    rx_bits++;
    if (rx_bits == 8) begin
      if (rx_n < 32) rx_mem[rx_n] = rx_sh;
      rx_n++;
      rx_bits = 0;
    end
  end

  always @(negedge clk_i) if (cclk_o) hi_cyc++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 37 + i * 91 + 5);
  endfunction

  task automatic pulse_start;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  task automatic bring_to_shift;
    init_i = 1'b1; done_i = 1'b0;
    pulse_start();
    chk("R2 prog low", {31'd0, prog_no}, 32'd0);
    chk("R2 busy", {31'd0, busy_o}, 32'd1);
    chk("R8 err cleared by start", {30'd0, err_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    init_i = 1'b0;
    @(negedge clk_i);
    chk("R3 prog released", {31'd0, prog_no}, 32'd1);
    repeat (2) @(negedge clk_i);
    init_i = 1'b1;
    @(negedge clk_i);
    rx_n = 0; rx_bits = 0; hi_cyc = 0;
  endtask

  task automatic feed(input int n, input int seed, input bit glitch);
    for (int i = 0; i < n; i++) begin
      byte_i = pat(seed, i); byte_last_i = (i == n - 1); byte_valid_i = 1'b1;
      while (!byte_ready_o) @(negedge clk_i);
      @(negedge clk_i);
      byte_valid_i = 1'b0; byte_last_i = 1'b0;
      if (i == 0) chk("R6 not ready while shifting", {31'd0, byte_ready_o}, 32'd0);
      if (glitch && i == 0) begin
        pulse_start();
        chk("R9 start ignored", {31'd0, prog_no}, 32'd1);
      end
    end
  endtask

  task automatic t_load(input int n, input int seed, input bit glitch);
    bring_to_shift();
    feed(n, seed, glitch);
    repeat (16 * HALF + 8) @(negedge clk_i);
    chk("R7 waits for done", {31'd0, busy_o}, 32'd1);
    done_i = 1'b1;
    @(negedge clk_i);
    chk("R7 ok", {31'd0, ok_o}, 32'd1);
    chk("R7 not busy", {31'd0, busy_o}, 32'd0);
    chk("R7 no err", {30'd0, err_o}, 32'd0);
    chk("R10 cclk idle", {31'd0, cclk_o}, 32'd0);
    chk("R5 byte count", rx_n, n);
    for (int i = 0; i < n && i < 32; i++)
      chk("R5 byte msb first", {24'd0, rx_mem[i]}, {24'd0, pat(seed, i)});
    chk("R5 cclk high cycles", hi_cyc, n * 8 * HALF);
    done_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R8 ok held", {31'd0, ok_o}, 32'd1);
  endtask

  task automatic t_init_low_to;
    int cyc = 0;
    init_i = 1'b1;
    pulse_start();
    while (busy_o) begin cyc++; @(negedge clk_i); end
    chk("R3 timeout length", cyc, T_IL);
    chk("R3 err code", {30'd0, err_o}, 32'd1);
    chk("R3 prog high", {31'd0, prog_no}, 32'd1);
  endtask

  task automatic t_init_high_to;
    int cyc = 0;
    init_i = 1'b1;
    pulse_start();
    repeat (2) @(negedge clk_i);
    init_i = 1'b0;
    @(negedge clk_i);
    while (busy_o) begin cyc++; @(negedge clk_i); end
    chk("R4 timeout length", cyc, T_IH);
    chk("R4 err code", {30'd0, err_o}, 32'd2);
    init_i = 1'b1;
  endtask

  task automatic t_done_to;
    int cyc = 0;
    bring_to_shift();
    feed(2, 7, 1'b0);
    while (busy_o && cyc < 500) begin cyc++; @(negedge clk_i); end
    chk("R7 done timeout code", {30'd0, err_o}, 32'd3);
    chk("R7 no ok", {31'd0, ok_o}, 32'd0);
    done_i = 1'b1; init_i = 1'b0; byte_valid_i = 1'b1;
    repeat (4) @(negedge clk_i);
    done_i = 1'b0; init_i = 1'b1; byte_valid_i = 1'b0;
    chk("R8 err held", {30'd0, err_o}, 32'd3);
    chk("R8 stays stopped", {31'd0, busy_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 prog", {31'd0, prog_no}, 32'd1);
    chk("R1 busy", {31'd0, busy_o}, 32'd0);
    chk("R1 ok", {31'd0, ok_o}, 32'd0);
    chk("R1 err", {30'd0, err_o}, 32'd0);
    chk("R1 cclk", {31'd0, cclk_o}, 32'd0);
    chk("R1 ready", {31'd0, byte_ready_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_load(4, 1, 1'b0);
    t_load(3, 2, 1'b1);
    t_init_low_to();
    t_init_high_to();
    t_done_to();
    t_load(1, 3, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule